// File: doc/BRIEF.md
# Phase-Tap Lock Status Tracker

This block keeps one lock-status flag for each receive channel of a dynamic phase-alignment circuit. The aligner reports two kinds of events to it: a pulse when it first settles on its best sampling tap, and a pulse each time it later moves that tap one step, with a bit giving the direction. The tracker turns this event stream into a steady flag that downstream logic reads to decide whether captured data can be trusted. It might, for example, reset a synchronising FIFO after the flag rises.

A static mode input sets how strict the flag is once lock has been found. In strict mode, any tap movement after lock drops the flag. In tolerant mode, which is the default, the flag drops only when two consecutive steps go in the same direction. A single step, or a step that reverses the previous one, is treated as normal jitter tracking. Once the flag has dropped, it stays low until the aligner reports a fresh lock. Reset clears every flag and every stored direction, so the aligner must train again.

All events and flags are synchronous to one clock. Each channel carries at most one event per cycle. A lock-found pulse has priority over a step pulse that arrives in the same cycle.

Top module: `phase_lock_tracker`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released, every bit of `locked` is 0.
- R2: A pulse on `found_evt[i]` makes `locked[i]` 1 from the next clock edge on.
- R3: With `strict_mode` = 1, a `step_evt[i]` pulse while `locked[i]` is 1 makes `locked[i]` 0 at the next clock edge.
- R4: With `strict_mode` = 0, the first step after lock leaves `locked[i]` at 1. A second step in the same direction (`step_up[i]` = 1 for up, 0 for down) clears it at the next edge.
- R5: With `strict_mode` = 0, a step opposite to the last recorded direction keeps `locked[i]` at 1. It also replaces the recorded direction, so only a following step in the new direction clears the flag.
- R6: While `locked[i]` is 0, step pulses have no effect. The flag stays 0 until `found_evt[i]` pulses.
- R7: When `found_evt[i]` and `step_evt[i]` pulse in the same cycle, the step is ignored. `locked[i]` becomes 1 and the direction history is cleared.
- R8: Each channel's flag depends only on that channel's events. Events on one channel never change another channel's flag.
- R9: Reset clears the direction history. After reset and a new lock, a single step does not clear the flag, even if it matches a step seen before the reset.
- R10: Steps received while unlocked leave no history. After a later lock, a single step does not clear the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for events and flags |
| rst_n | input | 1 | Asynchronous active-low reset |
| strict_mode | input | 1 | 1: drop lock on any step; 0: drop after two same-direction steps |
| found_evt | input | CHANNELS | Per-channel pulse: aligner found its best tap |
| step_evt | input | CHANNELS | Per-channel pulse: aligner moved its tap |
| step_up | input | CHANNELS | Direction of the step: 1 up, 0 down |
| locked | output | CHANNELS | Per-channel lock-status flag |

## Verification
Each channel's only hidden state is one stored direction and its valid bit. A corrupted history therefore stays invisible until the next step after lock. That step either drops the flag one edge early, or fails to drop it on the second same-direction step. The scenarios prime the history on purpose, with opposite steps, steps before lock, a reset mid-history, and a lock colliding with a step. They then issue exactly one further step and read the flag one edge later, so a stale history bit shows up within a single cycle. Cross-channel leakage is checked by comparing the full flag vector after every event.

// File: rtl/phase_lock_tracker.sv
module phase_lock_tracker #(
  parameter int CHANNELS = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                strict_mode,
  input  logic [CHANNELS-1:0] found_evt,
  input  logic [CHANNELS-1:0] step_evt,
  input  logic [CHANNELS-1:0] step_up,
  output logic [CHANNELS-1:0] locked
);

  logic [CHANNELS-1:0] hist_vld;
  logic [CHANNELS-1:0] hist_up;

  for (genvar i = 0; i < CHANNELS; i++) begin : g_ch
    logic step_hit;
    logic same_dir;
    logic lose;

    assign step_hit = step_evt[i] && !found_evt[i] && locked[i];
    assign same_dir = hist_vld[i] && (hist_up[i] == step_up[i]);
    assign lose     = step_hit && (strict_mode || same_dir);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        locked[i]   <= 1'b0;
        hist_vld[i] <= 1'b0;
        hist_up[i]  <= 1'b0;
      end else if (found_evt[i]) begin
        locked[i]   <= 1'b1;
        hist_vld[i] <= 1'b0;
      end else if (lose) begin
        locked[i]   <= 1'b0;
        hist_vld[i] <= 1'b0;
      end else if (step_hit) begin
        hist_vld[i] <= 1'b1;
        hist_up[i]  <= step_up[i];
      end
    end

    // R2
    found_sets_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      found_evt[i] |=> locked[i]);

    // R3
    strict_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      strict_mode && locked[i] && step_evt[i] && !found_evt[i] |=> !locked[i]);

    // R4
    first_step_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !strict_mode && locked[i] && !hist_vld[i] && step_evt[i] && !found_evt[i]
      |=> locked[i]);

    // R6
    stay_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !locked[i] && !found_evt[i] |=> !locked[i]);

    // R10
    no_hist_unlocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !locked[i] && !found_evt[i] |=> $stable(hist_vld[i]));
  end

endmodule

// File: tb/phase_lock_tracker_test.sv
module phase_lock_tracker_test;
  localparam int CH = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          strict_mode = 1'b0;
  logic [CH-1:0] found_evt = '0;
  logic [CH-1:0] step_evt = '0;
  logic [CH-1:0] step_up = '0;
  logic [CH-1:0] locked;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  phase_lock_tracker #(.CHANNELS(CH)) uut (
    .clk(clk), .rst_n(rst_n), .strict_mode(strict_mode),
    .found_evt(found_evt), .step_evt(step_evt), .step_up(step_up),
    .locked(locked)
  );

  task automatic chk(input logic [CH-1:0] exp, input string req);
    tests++;
    if (locked !== exp) begin
      fails++;
      $display("FAIL %s: locked actual=%b expected=%b", req, locked, exp);
    end
  endtask

  task automatic do_reset(input logic mode);
    @(negedge clk);
    rst_n = 1'b0;
    strict_mode = mode;
    found_evt = '0; step_evt = '0; step_up = '0;
    @(negedge clk);
    chk('0, "R1");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk('0, "R1");
  endtask

  task automatic ev(input logic [CH-1:0] f, input logic [CH-1:0] s,
                    input logic [CH-1:0] u);
    @(negedge clk);
    found_evt = f; step_evt = s; step_up = u;
    @(negedge clk);
    found_evt = '0; step_evt = '0; step_up = '0;
  endtask

  task automatic t_found;
    do_reset(1'b0);
    ev(4'b0001, '0, '0);           chk(4'b0001, "R2");
    ev(4'b0100, 4'b1000, 4'b1000); chk(4'b0101, "R8");
  endtask

  task automatic t_strict;
    do_reset(1'b1);
    ev(4'b1111, '0, '0);           chk(4'b1111, "R2");
    ev('0, 4'b0010, 4'b0010);      chk(4'b1101, "R3");
    ev('0, 4'b1000, 4'b0000);      chk(4'b0101, "R3");
    ev(4'b0001, 4'b0001, 4'b0001); chk(4'b0101, "R7");
  endtask

  task automatic t_tolerant;
    do_reset(1'b0);
    ev(4'b0101, '0, '0);           chk(4'b0101, "R2");
    ev('0, 4'b0101, 4'b0001);      chk(4'b0101, "R4");
    ev('0, 4'b0001, 4'b0001);      chk(4'b0100, "R4");
    ev('0, 4'b0100, 4'b0000);      chk(4'b0000, "R4");
  endtask

  task automatic t_opposite;
    do_reset(1'b0);
    ev(4'b0001, '0, '0);           chk(4'b0001, "R2");
    ev('0, 4'b0001, 4'b0001);      chk(4'b0001, "R5");
    ev('0, 4'b0001, 4'b0000);      chk(4'b0001, "R5");
    ev('0, 4'b0001, 4'b0001);      chk(4'b0001, "R5");
    ev('0, 4'b0001, 4'b0001);      chk(4'b0000, "R5");
  endtask

  task automatic t_stay_low;
    ev('0, 4'b0001, 4'b0001);      chk(4'b0000, "R6");
    ev('0, 4'b0001, 4'b0001);      chk(4'b0000, "R6");
    ev('0, 4'b0001, 4'b0000);      chk(4'b0000, "R6");
    ev(4'b0001, '0, '0);           chk(4'b0001, "R6");
  endtask

  task automatic t_collision;
    do_reset(1'b0);
    ev(4'b0010, '0, '0);           chk(4'b0010, "R2");
    ev('0, 4'b0010, 4'b0010);      chk(4'b0010, "R4");
    ev(4'b0010, 4'b0010, 4'b0010); chk(4'b0010, "R7");
    ev('0, 4'b0010, 4'b0010);      chk(4'b0010, "R7");
    ev('0, 4'b0010, 4'b0010);      chk(4'b0000, "R7");
  endtask

  task automatic t_reset_hist;
    do_reset(1'b0);
    ev(4'b1000, '0, '0);           chk(4'b1000, "R2");
    ev('0, 4'b1000, 4'b1000);      chk(4'b1000, "R4");
    do_reset(1'b0);
    ev(4'b1000, '0, '0);           chk(4'b1000, "R9");
    ev('0, 4'b1000, 4'b1000);      chk(4'b1000, "R9");
  endtask

  task automatic t_unlocked_steps;
    do_reset(1'b0);
    ev('0, 4'b0100, 4'b0000);      chk(4'b0000, "R10");
    ev(4'b0100, '0, '0);           chk(4'b0100, "R10");
    ev('0, 4'b0100, 4'b0000);      chk(4'b0100, "R10");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    t_found();
    t_strict();
    t_tolerant();
    t_opposite();
    t_stay_low();
    t_collision();
    t_reset_hist();
    t_unlocked_steps();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule